// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial bit stream into characters held in a one-byte receive buffer. A line that falls while idle is qualified as a start bit by a three-sample majority vote at mid-bit, driven by a 16x oversampling tick from an external baud generator. Each frame carries 7 or 8 data bits least significant first, an optional address bit, an optional parity bit and one stop bit. The receiver can take its input either from the external pin or from an internal loopback source.

Every completed character is judged for framing, parity and break errors. An acceptance rule then decides whether the character is written to the buffer and raises the receive flag. That rule depends on the error-interrupt enable, on the wake-interrupt enable and on whether the character carries a set address bit. The error flags are sticky. The overrun, the summary error and the receive flag are all cleared by a single read strobe on the bus side.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, rx_flag, is_addr, rx_byte and all error outputs are 0.
- R2: A frame is a low start bit, then 7 (cfg_eight=0) or 8 (cfg_eight=1) data bits sent LSB first, then an address bit if cfg_addr_mode=1, then a parity bit if cfg_par_en=1, then one stop bit. Each bit lasts 16 ticks. An accepted character is written to rx_byte and sets rx_flag.
- R3: In 7-bit mode the received byte is right-justified and rx_byte[7] is 0.
- R4: Only one stop bit is checked. A low stop bit sets err_frame, and extra high stop bits cause no error.
- R5: err_parity is set for a character whose parity is wrong. The address bit is part of the parity check. cfg_par_even=1 selects even parity and 0 selects odd parity. err_parity reads 0 while cfg_par_en=0.
- R6: A frame with every bit low, the stop bit included, sets err_break (and err_frame).
- R7: err_overrun is set when a character is accepted while rx_flag is still 1 and no read occurs in that cycle.
- R8: err_any is 1 whenever any of err_frame, err_parity, err_overrun or err_break is 1.
- R9: A one-cycle buf_rd pulse clears rx_flag, err_overrun, err_frame, err_parity, err_break and err_any on the next clock edge.
- R10: With cfg_err_ie=0 a character with a framing, parity or break error is rejected: rx_byte, rx_flag and is_addr stay unchanged, although its error flags are still set. With cfg_err_ie=1 such a character is accepted.
- R11: With cfg_wake_ie=1 only characters with a set address bit are accepted.
- R12: is_addr takes the address bit (1 = address, 0 = data) of each accepted character.
- R13: With loop_en=1 the receiver samples loop_line and ignores rx_line.
- R14: A low pulse whose mid-bit majority vote reads high is discarded as a false start and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input pin |
| loop_line | input | 1 | Internal loopback source |
| loop_en | input | 1 | Selects loop_line as input |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| cfg_eight | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even, 0 = odd parity |
| cfg_addr_mode | input | 1 | Address bit present |
| cfg_err_ie | input | 1 | Accept erroneous characters |
| cfg_wake_ie | input | 1 | Accept address characters only |
| buf_rd | input | 1 | Receive buffer read strobe |
| rx_byte | output | 8 | Receive buffer |
| rx_flag | output | 1 | Receive flag |
| err_frame | output | 1 | Framing error |
| err_parity | output | 1 | Parity error |
| err_overrun | output | 1 | Overrun error |
| err_break | output | 1 | Break detected |
| err_any | output | 1 | Summary error |
| is_addr | output | 1 | Last accepted character was an address |

## Verification
Character results are written one clock after the tick that ends the stop bit. That tick lands within a few clocks of the moment the bench stops driving the stop bit, because of the two-flop synchronizer and the up-to-one-tick detection delay. The bench therefore samples 40 clocks after the stop bit ends and then leaves more than one bit time of idle line before the next frame, so a false-start check that may follow a break is over before the next frame starts. Read effects are due on the clock edge that sees buf_rd, and the bench samples them at the following falling edge.

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       loop_line,
  input  logic       loop_en,
  input  logic       tick,
  input  logic       cfg_eight,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_addr_mode,
  input  logic       cfg_err_ie,
  input  logic       cfg_wake_ie,
  input  logic       buf_rd,
  output logic [7:0] rx_byte,
  output logic       rx_flag,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_break,
  output logic       err_any,
  output logic       is_addr
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;

  st_t        st;
  logic [1:0] sync;
  logic [CW-1:0] cnt;
  logic [2:0] vote;
  logic [3:0] idx;
  logic [9:0] fbits;
  logic       pe_q;

  wire line_s  = sync[1];
  wire maj     = (vote[0] & vote[1]) | (vote[0] & vote[2]) | (vote[1] & vote[2]);
  wire bit_end = tick && (cnt == CW'(OSR - 1));
  wire smp     = tick && (cnt == CW'(MID - 1) || cnt == CW'(MID) || cnt == CW'(MID + 1));

  wire [3:0] ndat  = cfg_eight ? 4'd8 : 4'd7;
  wire [3:0] nbits = ndat + {3'b0, cfg_addr_mode} + {3'b0, cfg_par_en};
  wire [9:0] vmask = (10'd1 << nbits) - 10'd1;
  wire [9:0] tail  = fbits >> ndat;
  wire [7:0] dat   = cfg_eight ? fbits[7:0] : {1'b0, fbits[6:0]};
  wire       abit  = cfg_addr_mode & tail[0];
  wire       pbit  = cfg_par_en & (cfg_addr_mode ? tail[1] : tail[0]);

  wire done   = (st == S_STOP) && bit_end;
  wire fe_c   = ~maj;
  wire pe_c   = cfg_par_en & ((^dat ^ abit ^ pbit) == cfg_par_even);
  wire brk_c  = ~maj & ((fbits & vmask) == 10'd0);
  wire err_c  = fe_c | pe_c | brk_c;
  wire accept = done && (!err_c || cfg_err_ie) && (!cfg_wake_ie || abit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= 2'b11;
      st    <= S_IDLE;
      cnt   <= '0;
      vote  <= 3'b111;
      idx   <= '0;
      fbits <= '0;
    end else begin
      sync <= {sync[0], loop_en ? loop_line : rx_line};
      if (tick) begin
        if (st == S_IDLE) begin
          cnt <= '0;
          if (!line_s) st <= S_START;
        end else begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (smp) vote <= {vote[1:0], line_s};
          if (bit_end) begin
            case (st)
              S_START: begin
                if (maj) st <= S_IDLE;
                else begin
                  st    <= S_BITS;
                  idx   <= '0;
                  fbits <= '0;
                end
              end
              S_BITS: begin
                fbits[idx] <= maj;
                idx <= idx + 1'b1;
                if (idx == nbits - 4'd1) st <= S_STOP;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte     <= '0;
      rx_flag     <= 1'b0;
      err_frame   <= 1'b0;
      pe_q        <= 1'b0;
      err_overrun <= 1'b0;
      err_break   <= 1'b0;
      err_any     <= 1'b0;
      is_addr     <= 1'b0;
    end else begin
      rx_flag     <= (rx_flag & ~buf_rd) | accept;
      err_frame   <= (err_frame & ~buf_rd) | (done & fe_c);
      pe_q        <= (pe_q & ~buf_rd) | (done & pe_c);
      err_break   <= (err_break & ~buf_rd) | (done & brk_c);
      err_overrun <= (err_overrun & ~buf_rd) | (accept & rx_flag & ~buf_rd);
      err_any     <= (err_any & ~buf_rd) | (done & err_c) | (accept & rx_flag & ~buf_rd);
      if (accept) begin
        rx_byte <= dat;
        is_addr <= abit;
      end
    end
  end

  assign err_parity = pe_q & cfg_par_en;
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       buf_rd,
  input logic       done,
  input logic       accept,
  input logic       cfg_eight,
  input logic       cfg_wake_ie,
  input logic [7:0] rx_byte,
  input logic       rx_flag,
  input logic       err_frame,
  input logic       err_parity,
  input logic       err_overrun,
  input logic       err_break,
  input logic       err_any,
  input logic       is_addr
);
  // R8
  any_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame || err_parity || err_overrun || err_break) |-> err_any);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !done) |=> (!rx_flag && !err_overrun && !err_any));

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_flag && !buf_rd) |=> err_overrun);

  // R3
  seven_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_flag) && !cfg_eight) |-> !rx_byte[7]);

  // R11
  wake_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_flag) && cfg_wake_ie) |-> is_addr);

  // R6
  break_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_break) |-> err_frame);
endmodule

bind uart_rx_flags uart_rx_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .buf_rd(buf_rd), .done(done), .accept(accept),
  .cfg_eight(cfg_eight), .cfg_wake_ie(cfg_wake_ie), .rx_byte(rx_byte),
  .rx_flag(rx_flag), .err_frame(err_frame), .err_parity(err_parity),
  .err_overrun(err_overrun), .err_break(err_break), .err_any(err_any),
  .is_addr(is_addr)
);

// File: tb/uart_rx_flags_bench.sv
module uart_rx_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1, loop_line = 1'b1, loop_en = 1'b0, tick = 1'b0;
  logic cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_addr_mode = 1'b0;
  logic cfg_err_ie = 1'b0, cfg_wake_ie = 1'b0, buf_rd = 1'b0;
  logic [7:0] rx_byte;
  logic rx_flag, err_frame, err_parity, err_overrun, err_break, err_any, is_addr;

  int checks = 0, errors = 0;
  logic [7:0] e_byte = 8'h00;
  logic e_flag = 0, e_fe = 0, e_pe = 0, e_oe = 0, e_brk = 0, e_addr = 0;

  always #5 clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 3);
  end

  uart_rx_flags u_uart_rx_flags (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 rx_byte"}, rx_byte, e_byte);
    chk({tag, " R10/R11 rx_flag"}, rx_flag, e_flag);
    chk({tag, " R4 err_frame"}, err_frame, e_fe);
    chk({tag, " R5 err_parity"}, err_parity, e_pe & cfg_par_en);
    chk({tag, " R6 err_break"}, err_break, e_brk);
    chk({tag, " R7 err_overrun"}, err_overrun, e_oe);
    chk({tag, " R8 err_any"}, err_any, e_fe | e_pe | e_oe | e_brk);
    chk({tag, " R12 is_addr"}, is_addr, e_addr);
  endtask

  task automatic rd(input string tag);
    @(negedge clk) buf_rd = 1'b1;
    @(negedge clk) buf_rd = 1'b0;
    e_flag = 0; e_fe = 0; e_pe = 0; e_oe = 0; e_brk = 0;
    check_all({tag, " R9 read"});
  endtask

  task automatic drive(input logic v, input int n, input logic lp);
    if (lp) loop_line = v; else rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic a, input logic pflip,
                       input logic stop, input logic lp, input string tag);
    logic [7:0] dm;
    logic p, am, fe, pe, brk, accept;
    int nd;
    nd = cfg_eight ? 8 : 7;
    dm = cfg_eight ? d : {1'b0, d[6:0]};
    am = cfg_addr_mode & a;
    p  = (^dm ^ am) ^ ~cfg_par_even ^ pflip;
    @(negedge clk);
    drive(1'b0, 64, lp);
    for (int i = 0; i < nd; i++) drive(dm[i], 64, lp);
    if (cfg_addr_mode) drive(a, 64, lp);
    if (cfg_par_en) drive(p, 64, lp);
    drive(stop, 64, lp);
    if (lp) loop_line = 1'b1; else rx_line = 1'b1;
    repeat (40) @(negedge clk);
    fe  = ~stop;
    pe  = cfg_par_en & pflip;
    brk = ~stop & (dm == 8'h00) & ~am & ~(cfg_par_en & p);
    accept = (!(fe | pe | brk) || cfg_err_ie) && (!cfg_wake_ie || am);
    if (accept) begin
      if (e_flag) e_oe = 1;
      e_byte = dm; e_flag = 1; e_addr = am;
    end
    e_fe |= fe; e_pe |= pe; e_brk |= brk;
    check_all(tag);
    repeat (60) @(negedge clk);
  endtask

  task automatic set_cfg(input logic e8, pen, pev, am, eie, wie);
    cfg_eight = e8; cfg_par_en = pen; cfg_par_even = pev;
    cfg_addr_mode = am; cfg_err_ie = eie; cfg_wake_ie = wie;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    // R1 reset state
    check_all("R1 reset");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check_all("R1 after release");

    set_cfg(1, 0, 0, 0, 0, 0);
    frame(8'hA5, 0, 0, 1, 0, "R2 8-bit");
    // R7 overrun on unread second frame, then R9 read
    frame(8'h3C, 0, 0, 1, 0, "R7 overrun");
    rd("R9");
    // R3 7-bit MSB forced low
    set_cfg(0, 0, 0, 0, 0, 0);
    frame(8'hFF, 0, 0, 1, 0, "R3 7-bit");
    rd("R3");
    // R4 low stop, rejected with err_ie=0
    set_cfg(1, 0, 0, 0, 0, 0);
    frame(8'h81, 0, 0, 0, 0, "R4 R10 reject");
    rd("R4");
    // R10 accepted with err_ie=1
    set_cfg(1, 1, 1, 0, 1, 0);
    frame(8'h55, 0, 1, 1, 0, "R5 R10 accept");
    rd("R5");
    // R5 address bit counted in parity (odd)
    set_cfg(1, 1, 0, 1, 0, 0);
    frame(8'h01, 1, 0, 1, 0, "R5 addr in parity good");
    frame(8'h01, 1, 1, 1, 0, "R5 addr in parity bad");
    rd("R5b");
    // R6 break
    set_cfg(1, 0, 0, 0, 1, 0);
    frame(8'h00, 0, 0, 0, 0, "R6 break");
    rd("R6");
    // R11 wake filtering and R12
    set_cfg(1, 0, 0, 1, 0, 1);
    frame(8'h12, 0, 0, 1, 0, "R11 data dropped");
    frame(8'h34, 1, 0, 1, 0, "R11 R12 address");
    set_cfg(1, 0, 0, 1, 0, 0);
    frame(8'h56, 0, 0, 1, 0, "R12 data");
    rd("R12");
    // R4 two stop bits: extra high bit is just idle
    set_cfg(1, 0, 0, 0, 0, 0);
    frame(8'hC3, 0, 0, 1, 0, "R4 two stop");
    rd("R4b");
    // R13 loopback; rx_line held low and ignored
    loop_en = 1'b1; rx_line = 1'b0;
    frame(8'h9E, 0, 0, 1, 1, "R13 loopback");
    rx_line = 1'b1; repeat (10) @(negedge clk); loop_en = 1'b0;
    rd("R13");
    // R14 false start glitch
    rx_line = 1'b0; repeat (8) @(negedge clk); rx_line = 1'b1;
    repeat (150) @(negedge clk);
    check_all("R14 glitch");

    for (int n = 0; n < 60; n++) begin
      logic [7:0] d;
      logic a, pf, st;
      set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
              $urandom % 2, ($urandom % 4) == 0);
      d  = 8'($urandom);
      a  = $urandom % 2;
      pf = ($urandom % 6) == 0;
      st = ($urandom % 8) != 0;
      if (d == 8'h00) d = 8'h01;
      frame(d, a, pf, st, 0, "rand R2");
      if ($urandom % 2) rd("rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule